// File: doc/BRIEF.md
# BT.656 Embedded Sync Formatter

This block turns a stream of 4:2:2 luma and chroma samples into the 8-bit parallel byte stream defined by ITU-R BT.656. A horizontal byte counter and a frame line counter run off a byte-rate clock enable. Each line starts with an end-of-active-video timing code, carries blanking fill, then a start-of-active-video code, and then the active samples in Cb, Y, Cr, Y order. Each timing code ends in a status byte that carries the field flag, the vertical blanking flag, the code type flag and four protection bits. A mode input selects 525-line or 625-line timing. The field and blanking flags follow the standard line tables for that mode.

The same counters drive the discrete timing outputs: a horizontal sync pulse, a vertical sync pulse, a field indicator, a vertical blanking indicator and an active video indicator. Cropping inputs narrow the active video indicator to a range of pixels within the line and a range of lines within each field. In discrete-sync mode the timing code positions carry blanking fill instead of codes. In embedded-sync mode the active video indicator rises four bytes earlier, at the first byte of the start code.

Top module: `bt656_formatter`

## Requirements
- R1: In embedded mode (`emb_en`=1) every timing code is the four bytes FFh, 00h, 00h, S. The status byte S holds, from bit 7 down to bit 0: 1, F, V, H, V^H, F^H, F^V, F^V^H.
- R2: The end code (H=1) occupies bytes 0..3 of every line. The start code (H=0) occupies the four bytes just before the first active byte. There is exactly one of each per line.
- R3: A line is 2*TOTAL_525 bytes long when `std625`=0 and 2*TOTAL_625 bytes long when `std625`=1. Its last 4*ACTIVE_PIX/2 bytes are active. Active byte k (counted from the first active byte) carries `in_cb` when k mod 4 = 0, `in_y` when k mod 4 is 1 or 3, and `in_cr` when k mod 4 = 2.
- R4: Blanking bytes carry 80h at even byte positions of the line and 10h at odd ones. When `emb_en`=0 the timing code positions carry blanking bytes as well.
- R5: F is 1 on lines 1..3 and 266..525 in 525 mode, and on lines 313..625 in 625 mode. V is 1 on lines 1..19 and 264..282 in 525 mode, and on lines 1..22, 311..335 and 624..625 in 625 mode. F and V take a new value only at an end code. A start code repeats the F and V of the end code before it. `out_fid` equals F.
- R6: A frame has 525 or 625 lines. The line number advances when the byte counter wraps from the last byte of a line to 0, and it wraps from the last line to line 1.
- R7: `out_hsync` is 1 for the first HSYNC_BYTES bytes of every line. `out_vsync` is 1 on the first VSYNC_LINES lines of each field. A field starts at line 4 or 266 in 525 mode and at line 1 or 313 in 625 mode.
- R8: `out_vblk` is 1 when V is 1, or when the line number within its field (counting from 1) is below `crop_vstart` or above `crop_vstop`.
- R9: `out_avid` is 1 on lines where `out_vblk` is 0, for the bytes of pixels `crop_hstart`..`crop_hstop`. Pixel p occupies active bytes 2p and 2p+1. When `emb_en`=1 the rising edge comes 4 bytes earlier.
- R10: While `clk_en` is 0, every output and both counters hold their values.
- R11: Synchronous active-high `rst` clears every output to 0 and sets the counters to byte 0 of line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Advances one byte per cycle when high |
| std625 | input | 1 | 1 selects 625-line timing, 0 selects 525-line timing |
| emb_en | input | 1 | 1 inserts timing codes, 0 gives discrete-sync output |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| crop_hstart | input | 10 | First pixel of the active window |
| crop_hstop | input | 10 | Last pixel of the active window |
| crop_vstart | input | 10 | First field line of the active window |
| crop_vstop | input | 10 | Last field line of the active window |
| out_byte | output | 8 | Formatted byte stream |
| out_hsync | output | 1 | Horizontal sync |
| out_vsync | output | 1 | Vertical sync |
| out_fid | output | 1 | Field indicator (1 = second field) |
| out_vblk | output | 1 | Vertical blanking with crop |
| out_avid | output | 1 | Active video indicator with crop |

## Verification
A wrong byte counter shows up within one line: the end code lands off byte 0, the start code no longer sits just before the samples, or the Cb/Y/Cr phase slips. All of these are caught on the byte where they first go wrong. A wrong line counter or field table first shows as a status byte with the wrong F or V, or a `out_fid`/`out_vblk` mismatch at the next end code. The bench also decodes the codes and adds up the line counts of consecutive fields, which catches frame-length errors within one frame and a half. Crop and sync errors show as an `out_avid`, `out_vsync` or `out_hsync` mismatch on the first byte of the affected line or pixel.

// File: rtl/fmt656_pkg.sv
package fmt656_pkg;

    // Line numbers reach 625, so ten bits are fixed by the standards.
    localparam int LINE_W = 10;

    typedef enum logic [1:0] {
        REG_BLANK  = 2'd0,
        REG_EAV    = 2'd1,
        REG_SAV    = 2'd2,
        REG_ACTIVE = 2'd3
    } region_e;

    typedef struct packed {
        logic f;
        logic v;
    } fv_t;

    typedef struct packed {
        logic [7:0] data;
        logic       hsync;
        logic       vsync;
        logic       fid;
        logic       vblk;
        logic       avid;
        logic       is_status;
    } fmt_out_t;

    // Status byte of a timing code with its protection bits.
    function automatic logic [7:0] status_byte(logic f, logic v, logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // Field and vertical blanking flags for a 1-based frame line.
    function automatic fv_t line_flags(logic [LINE_W-1:0] ln, logic is625);
        fv_t r;
        if (is625) begin
            r.f = (ln > 10'd312);
            r.v = (ln <= 10'd22) || (ln >= 10'd311 && ln <= 10'd335) || (ln >= 10'd624);
        end else begin
            r.f = (ln < 10'd4) || (ln > 10'd265);
            r.v = (ln <= 10'd19) || (ln >= 10'd264 && ln <= 10'd282);
        end
        return r;
    endfunction

    // 1-based line number inside the current field.
    function automatic logic [LINE_W-1:0] field_line(logic [LINE_W-1:0] ln, logic is625);
        logic [LINE_W-1:0] r;
        if (is625) begin
            r = (ln <= 10'd312) ? ln : ln - 10'd312;
        end else if (ln >= 10'd4 && ln <= 10'd265) begin
            r = ln - 10'd3;
        end else if (ln >= 10'd266) begin
            r = ln - 10'd265;
        end else begin
            r = ln + 10'd260;
        end
        return r;
    endfunction

endpackage

// File: rtl/fmt656_timing.sv
module fmt656_timing
    import fmt656_pkg::*;
#(
    parameter int TOTAL_525 = 858,
    parameter int TOTAL_625 = 864,
    parameter int H_W       = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              std625,
    output logic [H_W-1:0]    h_cnt,
    output logic [LINE_W-1:0] line,
    output logic [H_W-1:0]    line_bytes
);

    logic [LINE_W-1:0] frame_lines;

    always_comb begin
        line_bytes  = std625 ? H_W'(2 * TOTAL_625) : H_W'(2 * TOTAL_525);
        frame_lines = std625 ? LINE_W'(625) : LINE_W'(525);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt <= '0;
            line  <= LINE_W'(1);
        end else if (clk_en) begin
            if (h_cnt >= line_bytes - H_W'(1)) begin
                h_cnt <= '0;
                line  <= (line >= frame_lines) ? LINE_W'(1) : line + LINE_W'(1);
            end else begin
                h_cnt <= h_cnt + H_W'(1);
            end
        end
    end

    // R6: the line number moves only together with a wrap to byte 0
    a_r6_line_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (line != $past(line)) |-> (h_cnt == '0));

    // R3: the byte counter wraps only from the last byte of a line
    a_r3_wrap_at_end: assert property (@(posedge clk) disable iff (rst)
        (h_cnt == '0 && $past(h_cnt) != '0) |-> ($past(h_cnt) >= $past(line_bytes) - H_W'(1)));

endmodule

// File: rtl/fmt656_window.sv
module fmt656_window
    import fmt656_pkg::*;
#(
    parameter int ACTIVE_PIX  = 720,
    parameter int HSYNC_BYTES = 128,
    parameter int VSYNC_LINES = 3,
    parameter int H_W         = 11,
    parameter int PIX_W       = 10
) (
    input  logic              std625,
    input  logic              emb_en,
    input  logic [H_W-1:0]    h_cnt,
    input  logic [LINE_W-1:0] line,
    input  logic [H_W-1:0]    line_bytes,
    input  logic [PIX_W-1:0]  crop_hstart,
    input  logic [PIX_W-1:0]  crop_hstop,
    input  logic [LINE_W-1:0] crop_vstart,
    input  logic [LINE_W-1:0] crop_vstop,
    output region_e           region,
    output fv_t               flags,
    output logic              hsync,
    output logic              vsync,
    output logic              vblk,
    output logic              avid
);

    localparam int SW = H_W + PIX_W + 2;

    logic [H_W-1:0]    act_start;
    logic [LINE_W-1:0] fline;
    logic [SW-1:0]     pos_early, win_lo, win_hi;

    always_comb begin
        act_start = line_bytes - H_W'(2 * ACTIVE_PIX);
        if (h_cnt < H_W'(4))                     region = REG_EAV;
        else if (h_cnt >= act_start)             region = REG_ACTIVE;
        else if (h_cnt >= act_start - H_W'(4))   region = REG_SAV;
        else                                     region = REG_BLANK;

        flags = line_flags(line, std625);
        fline = field_line(line, std625);
        hsync = (h_cnt < H_W'(HSYNC_BYTES));
        vsync = (fline <= LINE_W'(VSYNC_LINES));
        vblk  = flags.v || (fline < crop_vstart) || (fline > crop_vstop);

        // Compare against the position four bytes ahead so no subtraction can wrap.
        pos_early = SW'(h_cnt) + SW'(4);
        win_lo    = SW'(act_start) + (SW'(crop_hstart) << 1) + (emb_en ? SW'(0) : SW'(4));
        win_hi    = SW'(act_start) + (SW'(crop_hstop) << 1) + SW'(1);
        avid      = !vblk && (pos_early >= win_lo) && (SW'(h_cnt) <= win_hi);
    end

endmodule

// File: rtl/fmt656_mux.sv
module fmt656_mux
    import fmt656_pkg::*;
(
    input  region_e    region,
    input  fv_t        flags,
    input  logic       emb_en,
    input  logic [1:0] idx,
    input  logic [7:0] in_y,
    input  logic [7:0] in_cb,
    input  logic [7:0] in_cr,
    output logic [7:0] data,
    output logic       is_status
);

    logic [7:0] fill;

    always_comb begin
        fill      = idx[0] ? 8'h10 : 8'h80;
        data      = fill;
        is_status = 1'b0;
        unique case (region)
            REG_EAV, REG_SAV: begin
                if (emb_en) begin
                    unique case (idx)
                        2'd0:    data = 8'hFF;
                        2'd3: begin
                            data      = status_byte(flags.f, flags.v, region == REG_EAV);
                            is_status = 1'b1;
                        end
                        default: data = 8'h00;
                    endcase
                end
            end
            REG_ACTIVE: begin
                unique case (idx)
                    2'd0:    data = in_cb;
                    2'd2:    data = in_cr;
                    default: data = in_y;
                endcase
            end
            default: data = fill;
        endcase
    end

endmodule

// File: rtl/bt656_formatter.sv
module bt656_formatter
    import fmt656_pkg::*;
#(
    parameter int ACTIVE_PIX  = 720,
    parameter int TOTAL_525   = 858,
    parameter int TOTAL_625   = 864,
    parameter int HSYNC_BYTES = 128,
    parameter int VSYNC_LINES = 3,
    parameter int PIX_W       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              std625,
    input  logic              emb_en,
    input  logic [7:0]        in_y,
    input  logic [7:0]        in_cb,
    input  logic [7:0]        in_cr,
    input  logic [PIX_W-1:0]  crop_hstart,
    input  logic [PIX_W-1:0]  crop_hstop,
    input  logic [LINE_W-1:0] crop_vstart,
    input  logic [LINE_W-1:0] crop_vstop,
    output logic [7:0]        out_byte,
    output logic              out_hsync,
    output logic              out_vsync,
    output logic              out_fid,
    output logic              out_vblk,
    output logic              out_avid
);

    localparam int TMAX = (TOTAL_625 > TOTAL_525) ? TOTAL_625 : TOTAL_525;
    localparam int H_W  = $clog2(2 * TMAX + 1);

    logic [H_W-1:0]    h_cnt, line_bytes;
    logic [LINE_W-1:0] line;
    region_e           region;
    fv_t               flags;
    fmt_out_t          nxt, q;

    fmt656_timing #(
        .TOTAL_525(TOTAL_525), .TOTAL_625(TOTAL_625), .H_W(H_W)
    ) u_timing (
        .clk(clk), .rst(rst), .clk_en(clk_en), .std625(std625),
        .h_cnt(h_cnt), .line(line), .line_bytes(line_bytes)
    );

    fmt656_window #(
        .ACTIVE_PIX(ACTIVE_PIX), .HSYNC_BYTES(HSYNC_BYTES),
        .VSYNC_LINES(VSYNC_LINES), .H_W(H_W), .PIX_W(PIX_W)
    ) u_window (
        .std625(std625), .emb_en(emb_en), .h_cnt(h_cnt), .line(line),
        .line_bytes(line_bytes), .crop_hstart(crop_hstart), .crop_hstop(crop_hstop),
        .crop_vstart(crop_vstart), .crop_vstop(crop_vstop),
        .region(region), .flags(flags), .hsync(nxt.hsync), .vsync(nxt.vsync),
        .vblk(nxt.vblk), .avid(nxt.avid)
    );

    fmt656_mux u_mux (
        .region(region), .flags(flags), .emb_en(emb_en), .idx(h_cnt[1:0]),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .data(nxt.data), .is_status(nxt.is_status)
    );

    assign nxt.fid = flags.f;

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (clk_en) q <= nxt;
    end

    always_comb begin
        out_byte  = q.data;
        out_hsync = q.hsync;
        out_vsync = q.vsync;
        out_fid   = q.fid;
        out_vblk  = q.vblk;
        out_avid  = q.avid;
    end

    // R1: every emitted status byte has its top bit set and consistent protection
    a_r1_status_bits: assert property (@(posedge clk) disable iff (rst)
        q.is_status |-> (q.data[7] && (q.data[3] == (q.data[5] ^ q.data[4]))
                         && (q.data[2] == (q.data[6] ^ q.data[4]))
                         && (q.data[1] == (q.data[6] ^ q.data[5]))
                         && (q.data[0] == (q.data[6] ^ q.data[5] ^ q.data[4]))));

    // R10: nothing moves at the outputs while the enable is low
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(out_byte) && $stable(out_avid) && $stable(out_fid)));

    // R7: vertical sync lines lie inside vertical blanking
    a_r7_vsync_in_blank: assert property (@(posedge clk) disable iff (rst)
        out_vsync |-> out_vblk);

    // R9: active video and horizontal sync never overlap
    a_r9_avid_no_hsync: assert property (@(posedge clk) disable iff (rst)
        out_avid |-> !out_hsync);

endmodule

// File: tb/tb_bt656_formatter.sv
module tb_bt656_formatter;

    localparam int ACT = 8;
    localparam int T5  = 14;
    localparam int T6  = 16;
    localparam int HSB = 8;
    localparam int VSL = 3;

    logic       clk = 1'b0, rst = 1'b1, clk_en = 1'b0, std625 = 1'b0, emb_en = 1'b1;
    logic [7:0] in_y = 8'h10, in_cb = 8'h80, in_cr = 8'h80;
    logic [9:0] crop_hstart = '0, crop_hstop = '0, crop_vstart = '0, crop_vstop = '0;
    logic [7:0] out_byte;
    logic       out_hsync, out_vsync, out_fid, out_vblk, out_avid;

    bt656_formatter #(
        .ACTIVE_PIX(ACT), .TOTAL_525(T5), .TOTAL_625(T6),
        .HSYNC_BYTES(HSB), .VSYNC_LINES(VSL), .PIX_W(10)
    ) dut (.*);

    always #4 clk = ~clk;

    int total_chk = 0, bad_chk = 0;
    bit done = 0;

    // model state
    int mh, mln;
    bit last_en;
    logic [7:0] e_byte;
    bit e_hs, e_vs, e_fid, e_vb, e_av;
    string e_tag;

    // decoder state
    logic [7:0] w0, w1, w2;
    int dec_eav, mod_eav, sav_since, seg_lines, prev_seg, f_edges;
    bit last_f, last_v, have_f;

    function automatic bit fb(int ln, bit m6);
        return m6 ? (ln >= 313) : (ln <= 3 || ln >= 266);
    endfunction

    function automatic bit vb(int ln, bit m6);
        if (m6) return ln <= 22 || (ln >= 311 && ln <= 335) || ln >= 624;
        return ln <= 19 || (ln >= 264 && ln <= 282);
    endfunction

    function automatic int flb(int ln, bit m6);
        if (m6) return (ln <= 312) ? ln : ln - 312;
        if (ln >= 4 && ln <= 265) return ln - 3;
        if (ln >= 266) return ln - 265;
        return ln + 260;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total_chk++;
        if (act != exp) begin
            bad_chk++;
            $display("FAIL %s actual=%0h expected=%0h (line %0d byte %0d)", tag, act, exp, mln, mh);
        end
    endtask

    task automatic predict();
        int tb = 2 * (std625 ? T6 : T5);
        int ast = tb - 2 * ACT;
        int ab = mh - ast;
        bit f = fb(mln, std625);
        bit v = vb(mln, std625);
        int fl = flb(mln, std625);
        bit code = (mh < 4) || (ab >= -4 && ab < 0);
        bit hb = (mh < 4);
        e_fid = f;
        e_hs  = (mh < HSB);
        e_vs  = (fl <= VSL);
        e_vb  = v || (fl < int'(crop_vstart)) || (fl > int'(crop_vstop));
        e_av  = !e_vb && (ab >= 2 * int'(crop_hstart) - (emb_en ? 4 : 0))
                && (ab <= 2 * int'(crop_hstop) + 1) && (ab >= -4);
        if (code && emb_en) begin
            e_tag = "R1";
            case (mh % 4)
                0: e_byte = 8'hFF;
                3: e_byte = {1'b1, f, v, hb, v ^ hb, f ^ hb, f ^ v, f ^ v ^ hb};
                default: e_byte = 8'h00;
            endcase
            if (mh == 3) mod_eav++;
        end else if (ab >= 0) begin
            e_tag = "R3";
            case (ab % 4)
                0: e_byte = in_cb;
                2: e_byte = in_cr;
                default: e_byte = in_y;
            endcase
        end else begin
            e_tag = "R4";
            e_byte = (mh % 2 == 1) ? 8'h10 : 8'h80;
        end
        // advance the model one byte
        if (mh >= tb - 1) begin
            mh = 0;
            mln = (mln >= (std625 ? 625 : 525)) ? 1 : mln + 1;
        end else begin
            mh++;
        end
    endtask

    task automatic decode(logic [7:0] b);
        if (w0 == 8'hFF && w1 == 8'h00 && w2 == 8'h00) begin
            chk("R1", int'(b[7] && b[3] == (b[5] ^ b[4]) && b[2] == (b[6] ^ b[4])
                          && b[1] == (b[6] ^ b[5]) && b[0] == (b[6] ^ b[5] ^ b[4])), 1);
            if (b[4]) begin
                if (dec_eav > 0) chk("R2", sav_since, 1);
                sav_since = 0;
                dec_eav++;
                if (have_f && b[6] != last_f) begin
                    f_edges++;
                    if (f_edges >= 3) chk("R6", prev_seg + seg_lines, std625 ? 625 : 525);
                    prev_seg  = seg_lines;
                    seg_lines = 0;
                end
                seg_lines++;
                last_f = b[6];
                last_v = b[5];
                have_f = 1;
            end else begin
                sav_since++;
                if (have_f) chk("R5", int'({b[6], b[5]}), int'({last_f, last_v}));
            end
        end
        w0 = w1; w1 = w2; w2 = b;
    endtask

    task automatic step();
        @(negedge clk);
        chk(last_en ? e_tag : "R10", out_byte, e_byte);
        chk(last_en ? "R7" : "R10", out_hsync, e_hs);
        chk(last_en ? "R7" : "R10", out_vsync, e_vs);
        chk(last_en ? "R5" : "R10", out_fid, e_fid);
        chk(last_en ? "R8" : "R10", out_vblk, e_vb);
        chk(last_en ? "R9" : "R10", out_avid, e_av);
        if (last_en && emb_en) decode(out_byte);
        clk_en = ($urandom_range(3) != 0);
        in_y   = 8'($urandom_range(253) + 1);
        in_cb  = 8'($urandom_range(253) + 1);
        in_cr  = 8'($urandom_range(253) + 1);
        if (clk_en) predict();
        last_en = clk_en;
    endtask

    task automatic run(bit m6, bit emb, int hs, int he, int vs, int ve, int nbytes);
        int n = 0;
        @(negedge clk);
        rst = 1; clk_en = 0;
        std625 = m6; emb_en = emb;
        crop_hstart = 10'(hs); crop_hstop = 10'(he);
        crop_vstart = 10'(vs); crop_vstop = 10'(ve);
        repeat (3) @(negedge clk);
        // R11: reset clears every output
        chk("R11", out_byte, 0);
        chk("R11", {out_hsync, out_vsync, out_fid, out_vblk, out_avid}, 0);
        rst = 0;
        mh = 0; mln = 1; last_en = 0;
        e_byte = 0; e_hs = 0; e_vs = 0; e_fid = 0; e_vb = 0; e_av = 0; e_tag = "R11";
        w0 = 0; w1 = 0; w2 = 0;
        dec_eav = 0; mod_eav = 0; sav_since = 0; seg_lines = 0; prev_seg = 0;
        f_edges = 0; have_f = 0; last_f = 0; last_v = 0;
        while (n < nbytes) begin
            step();
            if (last_en) n++;
        end
        step();
        if (emb) chk("R2", dec_eav, mod_eav);
    endtask

    initial begin
        void'($urandom(32'd656));
        // 525 embedded, full window: first byte after reset is the line-1 end code
        run(1'b0, 1'b1, 0, 1023, 0, 1023, 15000);
        // 625 embedded with a crop window in both directions
        run(1'b1, 1'b1, 2, 5, 30, 200, 30100);
        // 525 discrete with crop: codes replaced by fill, AVID starts at the pixel
        run(1'b0, 1'b0, 1, 6, 10, 250, 15000);
        // 625 discrete, crop stop beyond the line edge
        run(1'b1, 1'b0, 0, 1023, 0, 1023, 4000);
        done = 1;
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
            $finish;
        end
    end

endmodule